// File: doc/BRIEF.md
# Parallel RGB Panel Sync and Data-Enable Timing Generator

This block produces the line and frame timing for a parallel RGB panel driven from a pixel clock. It generates horizontal sync, vertical sync and data enable. It also produces a pixel-request strobe and active-area x/y coordinates, which the fetch and data path beside it consume. Software supplies the line total, the frame total, both sync widths, and the horizontal and vertical wait counts. Each wait count runs from the leading edge of its sync pulse to the first active pixel or line. Software also supplies the active pixel and line counts and the output polarities.

The timing parameters are captured into working copies only when a frame begins, so a reprogram in the middle of a frame cannot tear the picture. A frame-base address written into a pending slot is committed to the readable current-base output at the start of the next vsync. Dropping the run request lets the frame in progress finish before the engine reports that it has stopped.

Top module: `rgb_panel_timing`

## Requirements
- R1: During and immediately after reset, run_status is 0, cur_base is 0, px_x and px_y are 0, frame_start and pix_req are 0, and hsync, vsync and de sit at their inactive level.
- R2: A line lasts h_total clocks (horizontal count 0 to h_total−1), and hsync is active for the first h_sync_w clocks of each line. Every output follows the scan position by one clock.
- R3: A frame lasts v_total lines. With vs_in_lines=1, vsync is active for the first v_sync_w lines. With vs_in_lines=0, vsync is active for the first v_sync_w clocks of the frame.
- R4: Data enable and pix_req are active on lines v_wait to v_wait+v_active−1, and within those lines on horizontal counts h_wait to h_wait+h_active−1. Both counts are measured from the start of the sync pulse. pix_req is always active-high.
- R5: hs_high, vs_high and de_high each select an active-high (1) or active-low (0) level for their output. These bits act directly, without waiting for a frame boundary.
- R6: While sync_en is 0, hsync and vsync stay at their inactive level. Data enable is unaffected.
- R7: A write with nb_wr=1 loads the pending base. At the first clock of each frame, which is the cycle frame_start is high, cur_base takes the pending value held before that edge. cur_base changes at no other time.
- R8: All totals, widths, wait counts, active counts and vs_in_lines are captured when a frame begins. Changes made during a frame take effect only from the next frame.
- R9: Raising run_req while stopped starts a frame on the next clock. Clearing it lets the current frame finish, after which run_status drops to 0. A run_req raised again during that drain is ignored until the engine has stopped.
- R10: px_x = horizontal count − h_wait and px_y = line − v_wait while data enable is active. Otherwise both are 0.
- R11: With edge_fall=1, hsync, vsync, de, pix_req, px_x and px_y are relaunched on the falling clock edge and lag their rising-edge values by half a cycle.
- R12: frame_start is a one-clock pulse coinciding with the first clock of line 0, which is the first clock of vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Run request; clear to stop after the current frame |
| sync_en | input | 1 | Enables hsync and vsync |
| edge_fall | input | 1 | 1: outputs change on the falling clock edge |
| hs_high | input | 1 | hsync polarity, 1 = active high |
| vs_high | input | 1 | vsync polarity, 1 = active high |
| de_high | input | 1 | data enable polarity, 1 = active high |
| vs_in_lines | input | 1 | vsync width unit: 1 = lines, 0 = clocks |
| h_total | input | H_W | Line length in clocks |
| h_sync_w | input | H_W | hsync width in clocks |
| h_wait | input | H_W | Clocks from hsync start to first active pixel |
| h_active | input | H_W | Active pixels per line |
| v_total | input | V_W | Frame length in lines |
| v_sync_w | input | PW_W | vsync width (lines or clocks) |
| v_wait | input | V_W | Lines from vsync start to first active line |
| v_active | input | V_W | Active lines per frame |
| nb_wr | input | 1 | Write strobe for the pending frame base |
| nb_addr | input | A_W | Pending frame base value |
| run_status | output | 1 | Engine running or draining |
| frame_start | output | 1 | One-clock pulse at frame begin |
| cur_base | output | A_W | Frame base in use |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Active-high pixel request strobe |
| px_x | output | H_W | Active-area column |
| px_y | output | V_W | Active-area line |

## Verification
The hardest case to reach from the ports is a reprogram that lands inside a frame. It must leave the current frame untouched and take effect exactly at the next frame boundary. A run request that drops and rises again during the drain is nearly as hard. The stimulus handles both by drawing fresh random timing sets at random cycles while the engine runs, and by toggling run_req inside a frame. A cycle model in the bench keeps its own working copies and stop state, and predicts every output. Short random totals keep frames brief, so many frame boundaries, pending-base commits and clock-unit vsync widths occur in each run. The falling-edge mode is compared against the model's previous-cycle values.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;

   typedef enum logic [1:0] {
      TG_IDLE   = 2'd0,
      TG_ACTIVE = 2'd1,
      TG_DRAIN  = 2'd2
   } tg_state_e;

   // map an internal active flag to a pin level under a polarity select
   function automatic logic pin_level(input logic is_active, input logic act_high);
      return act_high ? is_active : ~is_active;
   endfunction

endpackage

// File: rtl/tg_scan.sv
module tg_scan
   import rgb_tg_pkg::*;
#(
   parameter int H_W  = 12,
   parameter int V_W  = 12,
   parameter int PW_W = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_req,
   input  logic [H_W-1:0]  ht,
   input  logic [V_W-1:0]  vt,
   output logic [H_W-1:0]  hc,
   output logic [V_W-1:0]  vc,
   output logic [PW_W-1:0] clkc,
   output logic            load,
   output logic            active,
   output logic            first
);

   localparam logic [PW_W-1:0] CLKC_MAX = '1;

   tg_state_e state;
   logic      h_end, v_end, last;

   assign h_end  = (hc == ht - H_W'(1));
   assign v_end  = (vc == vt - V_W'(1));
   assign last   = h_end && v_end;
   assign active = (state != TG_IDLE);
   assign first  = active && (hc == '0) && (vc == '0);
   assign load   = ((state == TG_IDLE) && run_req) ||
                   ((state == TG_ACTIVE) && last && run_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TG_IDLE;
         hc    <= '0;
         vc    <= '0;
         clkc  <= '0;
      end else if (state == TG_IDLE) begin
         hc   <= '0;
         vc   <= '0;
         clkc <= '0;
         if (run_req) state <= TG_ACTIVE;
      end else if (last) begin
         hc    <= '0;
         vc    <= '0;
         clkc  <= '0;
         state <= ((state == TG_ACTIVE) && run_req) ? TG_ACTIVE : TG_IDLE;
      end else begin
         if ((state == TG_ACTIVE) && !run_req) state <= TG_DRAIN;
         if (h_end) begin
            hc <= '0;
            vc <= vc + V_W'(1);
         end else begin
            hc <= hc + H_W'(1);
         end
         if (clkc != CLKC_MAX) clkc <= clkc + PW_W'(1);
      end
   end

endmodule

// File: rtl/tg_shape.sv
module tg_shape #(
   parameter int H_W  = 12,
   parameter int V_W  = 12,
   parameter int PW_W = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            first,
   input  logic            sync_en,
   input  logic            vs_lines,
   input  logic [H_W-1:0]  hc,
   input  logic [V_W-1:0]  vc,
   input  logic [PW_W-1:0] clkc,
   input  logic [H_W-1:0]  w_hsw,
   input  logic [H_W-1:0]  w_hw,
   input  logic [H_W-1:0]  w_ha,
   input  logic [PW_W-1:0] w_vsw,
   input  logic [V_W-1:0]  w_vw,
   input  logic [V_W-1:0]  w_va,
   output logic            hs_a,
   output logic            vs_a,
   output logic            de_a,
   output logic [H_W-1:0]  x_q,
   output logic [V_W-1:0]  y_q,
   output logic            fs_q
);

   logic [H_W:0] h_stop;
   logic [V_W:0] v_stop;
   logic         in_h, in_v, in_act, vs_hit;

   assign h_stop = {1'b0, w_hw} + {1'b0, w_ha};
   assign v_stop = {1'b0, w_vw} + {1'b0, w_va};
   assign in_h   = (hc >= w_hw) && ({1'b0, hc} < h_stop);
   assign in_v   = (vc >= w_vw) && ({1'b0, vc} < v_stop);
   assign in_act = active && in_h && in_v;
   assign vs_hit = vs_lines ? (PW_W'(vc) < w_vsw) : (clkc < w_vsw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_a <= 1'b0;
         vs_a <= 1'b0;
         de_a <= 1'b0;
         x_q  <= '0;
         y_q  <= '0;
         fs_q <= 1'b0;
      end else begin
         hs_a <= active && sync_en && (hc < w_hsw);
         vs_a <= active && sync_en && vs_hit;
         de_a <= in_act;
         x_q  <= in_act ? (hc - w_hw) : '0;
         y_q  <= in_act ? (vc - w_vw) : '0;
         fs_q <= first;
      end
   end

endmodule

// File: rtl/tg_launch.sv
module tg_launch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fall_sel,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] neg_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= '0;
      else        neg_q <= d;
   end

   assign q = fall_sel ? neg_q : d;

endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
   import rgb_tg_pkg::*;
#(
   parameter int H_W  = 12,
   parameter int V_W  = 12,
   parameter int PW_W = 18,
   parameter int A_W  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_req,
   input  logic            sync_en,
   input  logic            edge_fall,
   input  logic            hs_high,
   input  logic            vs_high,
   input  logic            de_high,
   input  logic            vs_in_lines,
   input  logic [H_W-1:0]  h_total,
   input  logic [H_W-1:0]  h_sync_w,
   input  logic [H_W-1:0]  h_wait,
   input  logic [H_W-1:0]  h_active,
   input  logic [V_W-1:0]  v_total,
   input  logic [PW_W-1:0] v_sync_w,
   input  logic [V_W-1:0]  v_wait,
   input  logic [V_W-1:0]  v_active,
   input  logic            nb_wr,
   input  logic [A_W-1:0]  nb_addr,
   output logic            run_status,
   output logic            frame_start,
   output logic [A_W-1:0]  cur_base,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic            pix_req,
   output logic [H_W-1:0]  px_x,
   output logic [V_W-1:0]  px_y
);

   localparam int LW = 3 + H_W + V_W;

   if (H_W < 2) begin : g_bad_hw
      $error("H_W must be at least 2");
   end
   if (V_W < 2) begin : g_bad_vw
      $error("V_W must be at least 2");
   end
   if (PW_W < V_W) begin : g_bad_pw
      $error("PW_W must not be narrower than V_W");
   end

   // working copies, captured at frame begin
   logic [H_W-1:0]  w_ht, w_hsw, w_hw, w_ha;
   logic [V_W-1:0]  w_vt, w_vw, w_va;
   logic [PW_W-1:0] w_vsw;
   logic            w_vl;
   logic [A_W-1:0]  pend_base;

   logic [H_W-1:0]  hc;
   logic [V_W-1:0]  vc;
   logic [PW_W-1:0] clkc;
   logic            load, active, first;
   logic            hs_a, vs_a, de_a, fs_q;
   logic [H_W-1:0]  x_q;
   logic [V_W-1:0]  y_q;
   logic [LW-1:0]   rise_bus, out_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_ht  <= '0;
         w_hsw <= '0;
         w_hw  <= '0;
         w_ha  <= '0;
         w_vt  <= '0;
         w_vsw <= '0;
         w_vw  <= '0;
         w_va  <= '0;
         w_vl  <= 1'b0;
      end else if (load) begin
         w_ht  <= h_total;
         w_hsw <= h_sync_w;
         w_hw  <= h_wait;
         w_ha  <= h_active;
         w_vt  <= v_total;
         w_vsw <= v_sync_w;
         w_vw  <= v_wait;
         w_va  <= v_active;
         w_vl  <= vs_in_lines;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_base <= '0;
         cur_base  <= '0;
      end else begin
         if (nb_wr) pend_base <= nb_addr;
         if (first) cur_base  <= pend_base;
      end
   end

   tg_scan #(.H_W(H_W), .V_W(V_W), .PW_W(PW_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_req (run_req),
      .ht      (w_ht),
      .vt      (w_vt),
      .hc      (hc),
      .vc      (vc),
      .clkc    (clkc),
      .load    (load),
      .active  (active),
      .first   (first)
   );

   tg_shape #(.H_W(H_W), .V_W(V_W), .PW_W(PW_W)) u_shape (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .first    (first),
      .sync_en  (sync_en),
      .vs_lines (w_vl),
      .hc       (hc),
      .vc       (vc),
      .clkc     (clkc),
      .w_hsw    (w_hsw),
      .w_hw     (w_hw),
      .w_ha     (w_ha),
      .w_vsw    (w_vsw),
      .w_vw     (w_vw),
      .w_va     (w_va),
      .hs_a     (hs_a),
      .vs_a     (vs_a),
      .de_a     (de_a),
      .x_q      (x_q),
      .y_q      (y_q),
      .fs_q     (fs_q)
   );

   assign rise_bus = {hs_a, vs_a, de_a, x_q, y_q};

   tg_launch #(.W(LW)) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_sel (edge_fall),
      .d        (rise_bus),
      .q        (out_bus)
   );

   assign hsync       = pin_level(out_bus[LW-1], hs_high);
   assign vsync       = pin_level(out_bus[LW-2], vs_high);
   assign de          = pin_level(out_bus[LW-3], de_high);
   assign pix_req     = out_bus[LW-3];
   assign px_x        = out_bus[H_W+V_W-1:V_W];
   assign px_y        = out_bus[V_W-1:0];
   assign frame_start = fs_q;
   assign run_status  = active;

endmodule

// File: rtl/rgb_tg_chk.sv
module rgb_tg_chk #(
   parameter int H_W = 12,
   parameter int V_W = 12,
   parameter int A_W = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           run_req,
   input logic           sync_en,
   input logic           edge_fall,
   input logic           hs_high,
   input logic           vs_high,
   input logic           run_status,
   input logic           frame_start,
   input logic           hsync,
   input logic           vsync,
   input logic           pix_req,
   input logic [A_W-1:0] cur_base,
   input logic [H_W-1:0] px_x,
   input logic [V_W-1:0] px_y
);

   // R6
   hsync_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && !edge_fall) |=> (edge_fall || (hsync == !hs_high)));

   // R6
   vsync_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && !edge_fall) |=> (edge_fall || (vsync == !vs_high)));

   // R10
   coord_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_req |-> (px_x == '0 && px_y == '0));

   // R7
   base_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_base) |-> frame_start);

   // R9
   run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_status) |-> $past(run_req));

   // R12
   frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(run_status));

endmodule

bind rgb_panel_timing rgb_tg_chk #(.H_W(H_W), .V_W(V_W), .A_W(A_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_req     (run_req),
   .sync_en     (sync_en),
   .edge_fall   (edge_fall),
   .hs_high     (hs_high),
   .vs_high     (vs_high),
   .run_status  (run_status),
   .frame_start (frame_start),
   .hsync       (hsync),
   .vsync       (vsync),
   .pix_req     (pix_req),
   .cur_base    (cur_base),
   .px_x        (px_x),
   .px_y        (px_y)
);

// File: tb/tb_rgb_panel_timing.sv
module tb_rgb_panel_timing;

   localparam int CLK_PERIOD = 10;
   localparam int H_W  = 12;
   localparam int V_W  = 12;
   localparam int PW_W = 18;
   localparam int A_W  = 32;
   localparam int CLKC_MAX = (1 << PW_W) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            run_req = 1'b0, sync_en = 1'b1, edge_fall = 1'b0;
   logic            hs_high = 1'b1, vs_high = 1'b1, de_high = 1'b1, vs_in_lines = 1'b1;
   logic [H_W-1:0]  h_total = '0, h_sync_w = '0, h_wait = '0, h_active = '0;
   logic [V_W-1:0]  v_total = '0, v_wait = '0, v_active = '0;
   logic [PW_W-1:0] v_sync_w = '0;
   logic            nb_wr = 1'b0;
   logic [A_W-1:0]  nb_addr = '0;
   logic            run_status, frame_start, hsync, vsync, de, pix_req;
   logic [A_W-1:0]  cur_base;
   logic [H_W-1:0]  px_x;
   logic [V_W-1:0]  px_y;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench model state
   int m_st, m_hc, m_vc, m_clkc;
   int w_ht, w_hsw, w_hw, w_ha, w_vt, w_vsw, w_vw, w_va, w_vl;
   longint m_next, m_cur;
   int e_hs, e_vs, e_de, e_x, e_y, e_fs;
   int p_hs, p_vs, p_de, p_x, p_y;

   always #(CLK_PERIOD/2) clk = ~clk;

   rgb_panel_timing #(.H_W(H_W), .V_W(V_W), .PW_W(PW_W), .A_W(A_W)) dut (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .sync_en(sync_en),
      .edge_fall(edge_fall), .hs_high(hs_high), .vs_high(vs_high),
      .de_high(de_high), .vs_in_lines(vs_in_lines),
      .h_total(h_total), .h_sync_w(h_sync_w), .h_wait(h_wait), .h_active(h_active),
      .v_total(v_total), .v_sync_w(v_sync_w), .v_wait(v_wait), .v_active(v_active),
      .nb_wr(nb_wr), .nb_addr(nb_addr),
      .run_status(run_status), .frame_start(frame_start), .cur_base(cur_base),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
      .px_x(px_x), .px_y(px_y)
   );

   function automatic int rr(input int lo, input int hi);
      return lo + int'($urandom % (hi - lo + 1));
   endfunction

   function automatic int lvl(input int act, input logic hi);
      return hi ? act : (act == 0 ? 1 : 0);
   endfunction

   task automatic chk1(input string tag, input string ph, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s] at %0t: actual %0h expected %0h", tag, ph, $time, act, exp);
      end
   endtask

   task automatic load_cfg();
      w_ht  = int'(h_total);  w_hsw = int'(h_sync_w); w_hw = int'(h_wait);
      w_ha  = int'(h_active); w_vt  = int'(v_total);  w_vsw = int'(v_sync_w);
      w_vw  = int'(v_wait);   w_va  = int'(v_active); w_vl = int'(vs_in_lines);
   endtask

   task automatic model_edge();
      int act, din, last, cont;
      if (!rst_n) begin
         m_st = 0; m_hc = 0; m_vc = 0; m_clkc = 0; m_next = 0; m_cur = 0;
         w_ht = 0; w_hsw = 0; w_hw = 0; w_ha = 0; w_vt = 0; w_vsw = 0;
         w_vw = 0; w_va = 0; w_vl = 0;
         e_hs = 0; e_vs = 0; e_de = 0; e_x = 0; e_y = 0; e_fs = 0;
         p_hs = 0; p_vs = 0; p_de = 0; p_x = 0; p_y = 0;
         return;
      end
      p_hs = e_hs; p_vs = e_vs; p_de = e_de; p_x = e_x; p_y = e_y;
      act  = (m_st != 0);
      e_hs = (act && sync_en && m_hc < w_hsw) ? 1 : 0;
      e_vs = (act && sync_en && (w_vl != 0 ? m_vc < w_vsw : m_clkc < w_vsw)) ? 1 : 0;
      din  = (act && m_hc >= w_hw && m_hc < w_hw + w_ha &&
              m_vc >= w_vw && m_vc < w_vw + w_va) ? 1 : 0;
      e_de = din;
      e_x  = din ? m_hc - w_hw : 0;
      e_y  = din ? m_vc - w_vw : 0;
      e_fs = (act && m_hc == 0 && m_vc == 0) ? 1 : 0;
      if (e_fs != 0) m_cur = m_next;
      if (nb_wr) m_next = longint'(nb_addr);
      if (m_st == 0) begin
         if (run_req) begin
            m_st = 1; m_hc = 0; m_vc = 0; m_clkc = 0; load_cfg();
         end
      end else begin
         last = (m_hc == w_ht - 1 && m_vc == w_vt - 1) ? 1 : 0;
         if (last != 0) begin
            cont = (m_st == 1 && run_req) ? 1 : 0;
            m_hc = 0; m_vc = 0; m_clkc = 0;
            if (cont != 0) load_cfg();
            m_st = cont;
         end else begin
            if (m_st == 1 && !run_req) m_st = 2;
            if (m_hc == w_ht - 1) begin m_hc = 0; m_vc++; end
            else m_hc++;
            if (m_clkc < CLKC_MAX) m_clkc++;
         end
      end
   endtask

   task automatic compare(input string ph);
      int rh, rv, rd, rx, ry;
      rh = edge_fall ? p_hs : e_hs;
      rv = edge_fall ? p_vs : e_vs;
      rd = edge_fall ? p_de : e_de;
      rx = edge_fall ? p_x  : e_x;
      ry = edge_fall ? p_y  : e_y;
      chk1("R2 hsync",       ph, longint'(hsync),  longint'(lvl(rh, hs_high)));
      chk1("R3 vsync",       ph, longint'(vsync),  longint'(lvl(rv, vs_high)));
      chk1("R4 de",          ph, longint'(de),     longint'(lvl(rd, de_high)));
      chk1("R4 pix_req",     ph, longint'(pix_req), longint'(rd));
      chk1("R10 px_x",       ph, longint'(px_x),   longint'(rx));
      chk1("R10 px_y",       ph, longint'(px_y),   longint'(ry));
      chk1("R12 frame_start", ph, longint'(frame_start), longint'(e_fs));
      chk1("R9 run_status",  ph, longint'(run_status), longint'(m_st != 0));
      chk1("R7 cur_base",    ph, longint'(cur_base), m_cur);
   endtask

   task automatic step(input string ph);
      @(posedge clk);
      model_edge();
      #3;
      compare(ph);
   endtask

   task automatic rand_cfg();
      int vsl;
      h_sync_w    = H_W'(rr(1, 3));
      h_wait      = H_W'(int'(h_sync_w) + rr(0, 3));
      h_total     = H_W'(rr(int'(h_wait) + 2, 24));
      h_active    = H_W'(rr(1, int'(h_total) - int'(h_wait)));
      vs_in_lines = (rr(0, 3) != 0);
      v_total     = V_W'(rr(4, 9));
      vsl         = rr(1, 2);
      v_wait      = V_W'(vsl + rr(0, 1));
      v_active    = V_W'(rr(1, int'(v_total) - int'(v_wait)));
      v_sync_w    = vs_in_lines ? PW_W'(vsl) : PW_W'(rr(1, 40));
   endtask

   task automatic rand_cycle(input string ph, input int n, input int cfg_pct);
      for (int i = 0; i < n; i++) begin
         step(ph);
         nb_wr   = (rr(0, 9) == 0);
         nb_addr = A_W'($urandom);
         if (rr(0, 99) < cfg_pct) rand_cfg();
      end
      nb_wr = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      // directed timing set A
      h_total = 12'd10; h_sync_w = 12'd2; h_wait = 12'd4; h_active = 12'd5;
      v_total = 12'd8;  v_sync_w = 18'd1; v_wait = 12'd3; v_active = 12'd3;

      // R1: reset state
      for (int i = 0; i < 3; i++) step("R1 reset");
      chk1("R1 run_status", "reset", longint'(run_status), 0);
      chk1("R1 cur_base",   "reset", longint'(cur_base), 0);
      chk1("R1 hsync",      "reset", longint'(hsync), 0);
      chk1("R1 de",         "reset", longint'(de), 0);
      chk1("R1 px_x",       "reset", longint'(px_x), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) step("R1 idle after reset");

      // R2 R3 R4 R12: directed frames, pending base written before start (R7)
      nb_wr = 1'b1; nb_addr = 32'hA000_0000;
      step("R7 write");
      nb_wr = 1'b0; run_req = 1'b1;
      for (int i = 0; i < 170; i++) step("R2 R3 directed");

      // R8: reprogram mid-frame, model keeps old working copies
      h_total = 12'd14; h_active = 12'd7; v_total = 12'd6;
      for (int i = 0; i < 200; i++) step("R8 midframe change");

      // R5: polarity selections, live
      hs_high = 1'b0; vs_high = 1'b0; de_high = 1'b0;
      for (int i = 0; i < 100; i++) step("R5 low polarity");
      hs_high = 1'b1; vs_high = 1'b1; de_high = 1'b1;

      // random timing sets with mid-frame changes and base writes
      for (int r = 0; r < 10; r++) begin
         hs_high = ($urandom % 2) != 0;
         vs_high = ($urandom % 2) != 0;
         de_high = ($urandom % 2) != 0;
         rand_cycle("R8 random", 300, 2);
      end

      // R6: sync gating
      sync_en = 1'b0;
      rand_cycle("R6 sync off", 200, 2);
      sync_en = 1'b1;

      // R9: stop, re-request during drain is ignored
      run_req = 1'b0;
      for (int i = 0; i < 5; i++) step("R9 drain");
      run_req = 1'b1;
      for (int i = 0; i < 5; i++) step("R9 rerequest in drain");
      run_req = 1'b0;
      for (int i = 0; i < 250; i++) step("R9 stop");
      chk1("R9 stopped", "after drain", longint'(run_status), 0);
      run_req = 1'b1;
      for (int i = 0; i < 100; i++) step("R9 restart");

      // R3: vsync width counted in clocks
      vs_in_lines = 1'b0; v_sync_w = 18'd15;
      h_total = 12'd10; h_sync_w = 12'd2; h_wait = 12'd4; h_active = 12'd5;
      v_total = 12'd8; v_wait = 12'd3; v_active = 12'd3;
      for (int i = 0; i < 250; i++) step("R3 clock units");

      // R11: falling-edge launch
      edge_fall = 1'b1;
      rand_cycle("R11 falling edge", 500, 2);
      edge_fall = 1'b0;
      rand_cycle("R11 back to rising", 200, 2);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule